// File: doc/BRIEF.md
# BCH Syndrome Expansion Unit

This unit takes the odd-indexed partial remainders that a NAND page's BCH decoder path leaves behind for one sector and expands them into the complete list of 2t syndromes S1..S2t over GF(2^m). The field is either GF(2^13), used with 512-byte sectors, or GF(2^14), used with 1024-byte sectors. The correction capability t is 2, 4, 8, 12 or 24.

Each odd syndrome is formed by evaluating its remainder polynomial at the matching power of the primitive element alpha. Every even syndrome is then obtained by squaring an earlier syndrome, since the code is binary. All field arithmetic uses shift-and-reduce logic, with no lookup ROM. A one-cycle start pulse hands over the inputs. A one-cycle done pulse marks the point where the full set of syndromes is valid on the output.

Top module: `bch_synd_expand`

## Requirements
- R1: `m_sel` = 0 selects GF(2^13) with primitive polynomial x^13+x^4+x^3+x+1. `m_sel` = 1 selects GF(2^14) with x^14+x^10+x^6+x+1. Field elements sit in the low m bits of each 14-bit slot, and alpha is the value 2.
- R2: `t_cap` gives the correction capability (2, 4, 8, 12 or 24). Exactly 2t syndromes are produced.
- R3: Remainder k is held at bits [14k+13:14k] of `rem_in`, for k = 0..t-1, and belongs to odd index i = 2k+1. The value S_i is the XOR of alpha^(i*j) over every bit j < m that is set in that remainder. Syndrome S_i is driven at bits [14(i-1)+13:14(i-1)] of `synd`.
- R4: Each even syndrome S_2j equals S_j squared in the selected field. A zero S_j yields a zero S_2j.
- R5: Every slot above S_2t reads zero after a run, including slots left over from an earlier run with a larger t.
- R6: `done` is a single-cycle pulse. It goes high on the (t*m + t)-th rising edge after the edge that samples `start`. `busy` is high from the edge after `start` until `done` rises.
- R7: A `start` pulse while `busy` is high is ignored. Changes to `rem_in`, `t_cap` or `m_sel` after `start` has been sampled do not affect the current result.
- R8: After reset, `busy` and `done` are low and all of `synd` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Latches the inputs and begins a run when idle |
| m_sel | input | 1 | Field select: 0 = GF(2^13), 1 = GF(2^14) |
| t_cap | input | 5 | Correction capability t |
| rem_in | input | 336 | Odd partial remainders, 14 bits each, remainder k belongs to S_(2k+1) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when all syndromes are valid |
| synd | output | 672 | Syndromes S1..S48, 14 bits each, S_i at slot i-1 |

## Verification
A run spends m cycles on each odd syndrome and one cycle on each even syndrome. As a result, `done` is due exactly t*m + t rising edges after the edge that samples `start`, and `synd` is final in that same cycle. The bench notes the edge count when it issues `start`. It samples `done` and `synd` on falling edges and compares the measured latency against t*m + t. It then compares the odd, even and unused slots of the syndrome vector against values computed from powers of alpha and from polynomial squaring. A spurious `done` from an ignored start shows up as a pulse with no matching expectation queued.

// File: rtl/bch_synd_expand.sv
module bch_synd_expand #(
  parameter int TMAX = 24,
  parameter int MW = 14,
  parameter logic [13:0] POLY13 = 14'h001B,
  parameter logic [13:0] POLY14 = 14'h0443
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   m_sel,
  input  logic [4:0]             t_cap,
  input  logic [TMAX*MW-1:0]     rem_in,
  output logic                   busy,
  output logic                   done,
  output logic [2*TMAX*MW-1:0]   synd
);
  localparam int NS = 2 * TMAX;
  localparam int TW = 5;

  typedef enum logic [1:0] {S_IDLE, S_ODD, S_EVEN} st_t;

  function automatic logic [MW-1:0] gf_x2(input logic [MW-1:0] x, input logic m14);
    logic [MW-1:0] y;
    y = {x[MW-2:0], 1'b0};
    if (m14) begin
      if (x[MW-1]) y = y ^ POLY14;
    end else begin
      y[MW-1] = 1'b0;
      if (x[MW-2]) y = y ^ POLY13;
    end
    return y;
  endfunction

  function automatic logic [MW-1:0] gf_mul(input logic [MW-1:0] a, input logic [MW-1:0] b,
                                           input logic m14);
    logic [MW-1:0] p;
    p = '0;
    for (int n = MW - 1; n >= 0; n--) begin
      p = gf_x2(p, m14);
      if (b[n]) p = p ^ a;
    end
    return p;
  endfunction

  st_t            st;
  logic [TW-1:0]  k, e, t_q;
  logic [3:0]     j;
  logic           m14_q;
  logic [MW-1:0]  acc, pw, base;
  logic [MW-1:0]  rem_q [TMAX];
  logic [MW-1:0]  syn [NS];

  wire [3:0]    j_last  = m14_q ? 4'd13 : 4'd12;
  wire [MW-1:0] acc_nxt = rem_q[k][j] ? (acc ^ pw) : acc;
  wire [MW-1:0] pw_nxt  = gf_mul(pw, base, m14_q);
  wire [MW-1:0] base_nx = gf_mul(base, 14'd4, m14_q);
  wire [MW-1:0] sq_src  = syn[e - TW'(1)];
  wire [MW-1:0] sq_res  = gf_mul(sq_src, sq_src, m14_q);

  assign busy = (st != S_IDLE);

  for (genvar g = 0; g < NS; g++) begin : g_out
    assign synd[g*MW +: MW] = syn[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; done <= 1'b0;
      k <= '0; e <= '0; j <= '0; t_q <= '0; m14_q <= 1'b0;
      acc <= '0; pw <= '0; base <= '0;
      for (int i = 0; i < TMAX; i++) rem_q[i] <= '0;
      for (int i = 0; i < NS; i++) syn[i] <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_ODD;
          t_q <= t_cap; m14_q <= m_sel;
          k <= '0; j <= '0; acc <= '0; pw <= 14'd1; base <= 14'd2;
          for (int i = 0; i < TMAX; i++) rem_q[i] <= rem_in[i*MW +: MW];
          for (int i = 0; i < NS; i++) syn[i] <= '0;
        end
        S_ODD: begin
          if (j == j_last) begin
            syn[{k, 1'b0}] <= acc_nxt;
            acc <= '0; pw <= 14'd1; base <= base_nx; j <= '0; k <= k + TW'(1);
            if (k == t_q - TW'(1)) begin
              st <= S_EVEN; e <= TW'(1);
            end
          end else begin
            acc <= acc_nxt; pw <= pw_nxt; j <= j + 4'd1;
          end
        end
        S_EVEN: begin
          syn[{e, 1'b0} - 6'd1] <= sq_res;
          if (e == t_q) begin
            st <= S_IDLE; done <= 1'b1;
          end else e <= e + TW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic hi_nz;
  always_comb begin
    hi_nz = 1'b0;
    for (int i = 0; i < NS; i++)
      if (i >= 2 * int'(t_q) && syn[i] != '0) hi_nz = 1'b1;
  end

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r6_done_idle:  assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  a_r7_cfg_hold:   assert property (@(posedge clk) disable iff (!rst_n)
                                    (busy && $past(busy)) |-> ($stable(t_q) && $stable(m14_q)));
  a_r5_high_zero:  assert property (@(posedge clk) disable iff (!rst_n) done |-> !hi_nz);
endmodule

// File: tb/bch_synd_expand_bench.sv
`timescale 1ns/1ps
module bch_synd_expand_bench;
  localparam int TMAX = 24;
  localparam int MW = 14;
  localparam int NS = 2 * TMAX;
  localparam int VW = NS * MW;
  localparam int RW = TMAX * MW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, m_sel = 1'b0;
  logic [4:0] t_cap = '0;
  logic [RW-1:0] rem_in = '0;
  logic busy, done;
  logic [VW-1:0] synd;

  int checks = 0, errors = 0, cyc = 0, start_cyc = 0;
  logic [VW-1:0] exp_q[$];
  int lat_q[$];
  logic [VW-1:0] odd_q[$], even_q[$], hi_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bch_synd_expand u_bch_synd_expand (
    .clk(clk), .rst_n(rst_n), .start(start), .m_sel(m_sel), .t_cap(t_cap),
    .rem_in(rem_in), .busy(busy), .done(done), .synd(synd));

  task automatic chk(input bit ok, input string tag, input logic [VW-1:0] act, input logic [VW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [13:0] times_alpha(input logic [13:0] x, input bit m14);
    logic [14:0] y;
    int mm;
    mm = m14 ? 14 : 13;
    y = {x, 1'b0};
    if (y[mm]) y = y ^ (m14 ? 15'h4443 : 15'h201B);
    return y[13:0];
  endfunction

  function automatic logic [13:0] apow(input int ex, input bit m14);
    logic [13:0] v;
    v = 14'd1;
    for (int n = 0; n < ex; n++) v = times_alpha(v, m14);
    return v;
  endfunction

  function automatic logic [13:0] square(input logic [13:0] s, input bit m14);
    logic [27:0] v;
    logic [27:0] pf;
    int mm;
    mm = m14 ? 14 : 13;
    pf = m14 ? 28'h4443 : 28'h201B;
    v = '0;
    for (int b = 0; b < 14; b++) v[2*b] = s[b];
    for (int b = 27; b >= mm; b--)
      if (v[b]) v = v ^ (pf << (b - mm));
    return v[13:0];
  endfunction

  task automatic run_case(input bit m14, input int t, input logic [RW-1:0] r);
    logic [VW-1:0] ev, om, emk, hm;
    int mm, n;
    mm = m14 ? 14 : 13;
    n = (1 << mm) - 1;
    ev = '0; om = '0; emk = '0; hm = '0;
    for (int k = 0; k < t; k++) begin
      logic [13:0] s;
      s = '0;
      for (int j = 0; j < mm; j++)
        if (r[k*MW + j]) s = s ^ apow(((2*k+1) * j) % n, m14);
      ev[2*k*MW +: MW] = s;
      om[2*k*MW +: MW] = '1;
    end
    for (int i = 2; i <= 2*t; i += 2) begin
      ev[(i-1)*MW +: MW] = square(ev[(i/2-1)*MW +: MW], m14);
      emk[(i-1)*MW +: MW] = '1;
    end
    hm = ~(om | emk);
    exp_q.push_back(ev); lat_q.push_back(t*mm + t);
    odd_q.push_back(om); even_q.push_back(emk); hi_q.push_back(hm);
    @(negedge clk);
    m_sel = m14; t_cap = 5'(t); rem_in = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0; start_cyc = cyc;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [RW-1:0] rnd_rem(input bit m14);
    logic [RW-1:0] r;
    for (int k = 0; k < TMAX; k++) r[k*MW +: MW] = 14'($urandom) & (m14 ? 14'h3FFF : 14'h1FFF);
    return r;
  endfunction

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (done && rst_n) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected done", synd, '0);
        end else begin
          logic [VW-1:0] ev, om, emk, hm;
          int lat;
          ev = exp_q.pop_front(); lat = lat_q.pop_front();
          om = odd_q.pop_front(); emk = even_q.pop_front(); hm = hi_q.pop_front();
          chk((cyc - start_cyc) == lat, "R6 done latency", VW'(cyc - start_cyc), VW'(lat));
          chk((synd & om) == (ev & om), "R1/R3 odd syndromes", synd & om, ev & om);
          chk((synd & emk) == (ev & emk), "R4 even syndromes", synd & emk, ev & emk);
          chk((synd & hm) == '0, "R2/R5 slots above 2t", synd & hm, '0);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    logic [RW-1:0] r;
    repeat (3) @(negedge clk);
    chk(!busy && !done && synd == '0, "R8 reset state", {synd[VW-3:0], busy, done}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    r = '0; r[0] = 1'b1;
    run_case(1'b0, 2, r); wait_idle();
    run_case(1'b1, 4, rnd_rem(1'b1)); wait_idle();
    r = rnd_rem(1'b0); r[1*MW +: MW] = '0;
    run_case(1'b0, 8, r); wait_idle();
    run_case(1'b1, 12, rnd_rem(1'b1)); wait_idle();
    run_case(1'b0, 24, rnd_rem(1'b0)); wait_idle();
    run_case(1'b1, 24, rnd_rem(1'b1)); wait_idle();
    run_case(1'b1, 24, '0); wait_idle();
    run_case(1'b0, 2, rnd_rem(1'b0)); wait_idle();
    r = rnd_rem(1'b0);
    run_case(1'b0, 2, r); wait_idle();
    r = rnd_rem(1'b1);
    run_case(1'b1, 4, r);
    repeat (10) @(negedge clk);
    m_sel = 1'b0; t_cap = 5'd24; rem_in = ~r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (200) @(negedge clk);
    chk(!busy, "R7 ignored start left unit idle", VW'(busy), '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule